// File: doc/BRIEF.md
# Triangular Frequency-Modulated PWM Carrier Timebase

This block produces a center-aligned up/down carrier for a three-phase modulator. The switching frequency is not fixed. It moves from one PWM cycle to the next along a triangular profile around a nominal value. The profile starts at the nominal frequency minus a deviation, climbs to the nominal frequency plus that deviation, and falls back again. One full sweep lasts exactly one fundamental period, which is given as a count of PWM cycles. Because the sweep is symmetric about the nominal value, the average switching frequency stays at the nominal one. The harmonic energy near the carrier frequency is spread over a band instead of being concentrated in one tone.

Frequencies are given as integer codes in units of one frequency quantum. For each code, the carrier half-period in clocks comes from a reciprocal table built at elaboration time, equal to `HALF_NUM / code`. The block therefore contains no divider. A new half-period is taken only when the counter sits at zero, so a cycle already running always completes unchanged. Downstream compare logic uses the counter value, the half-period, and two single-clock strobes: one at the cycle start (counter zero) and one at the peak.

Top module: `tri_fm_pwm_timebase`

## Requirements
- R1: While `rstN` is low, `carrierCnt` is 0, `halfPeriod` is 0, `cycleStart` is 1 and `cycleMid` is 0.
- R2: Each PWM cycle with half-period H lasts 2H clocks. `carrierCnt` reads 0 on the first clock, rises by one per clock to H, then falls by one per clock down to 1. The next cycle then begins at 0.
- R3: `cycleStart` is high for exactly the clocks where `carrierCnt` is 0. `cycleMid` is high for exactly one clock per cycle, the clock on which `carrierCnt` equals H.
- R4: `halfPeriod` changes only on the clock that follows a `cycleStart` clock. It then shows the H of the cycle that has just begun.
- R5: The half-period of PWM cycle k (k = 0 is the first cycle after reset) is floor(`HALF_NUM` / c_k). Here c_k = `nomCode` − `devAmp` + p_k, and p_k is the profile position.
- R6: The profile position starts at 0 after reset and moves by at most one code per PWM cycle. It rises to 2·`devAmp`, reverses, falls to 0, and reverses again. With s_k = floor(4·`devAmp`·k / `fundCycles`) mod (4·`devAmp`), p_k = s_k when s_k ≤ 2·`devAmp`, and p_k = 4·`devAmp` − s_k otherwise.
- R7: The half-period sequence repeats every `fundCycles` PWM cycles. Within one fundamental period its extremes are floor(`HALF_NUM`/(`nomCode`+`devAmp`)) and floor(`HALF_NUM`/(`nomCode`−`devAmp`)).
- R8: With `devAmp` = 0, every cycle uses the half-period floor(`HALF_NUM`/`nomCode`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nomCode | input | FREQ_W | Nominal switching frequency code |
| devAmp | input | FREQ_W | Frequency deviation amplitude, in codes |
| fundCycles | input | FUND_W | Fundamental period, in PWM cycles |
| carrierCnt | output | CNT_W | Up/down carrier counter |
| halfPeriod | output | CNT_W | Half-period of the running cycle, in clocks |
| cycleStart | output | 1 | High while the counter is at zero |
| cycleMid | output | 1 | High for the single peak clock |

## Verification
The assertions assume the inputs are legal and constant while the block is out of reset. Legal means `nomCode` − `devAmp` ≥ 1, `nomCode` + `devAmp` below 2^FREQ_W, 4·`devAmp` ≤ `fundCycles`, and `fundCycles` ≥ 1. Under these conditions every table entry reached is a non-zero half-period, and the profile makes at most one step per cycle. The stimulus changes the inputs only while `rstN` is low. Every configuration it applies stays inside these limits, including the edge 4·`devAmp` = `fundCycles` (a step in every cycle), an odd fundamental count, a zero deviation, and a sweep down to frequency code 1.

// File: rtl/tri_fm_pkg.sv
package tri_fm_pkg;

  // Direction of a ramp: used by the carrier counter and by the frequency profile.
  typedef enum logic {
    SLOPE_RISE = 1'b0,
    SLOPE_FALL = 1'b1
  } slope_e;

  // Events the carrier control hands to the frequency datapath.
  typedef struct packed {
    logic reload;  // counter at zero: cycle boundary, take a new half-period
    logic peak;    // counter at the top of the triangle
  } carrierEvt_t;

endpackage

// File: rtl/tri_fm_recip_rom.sv
module tri_fm_recip_rom #(
  parameter int FREQ_W   = 6,
  parameter int CNT_W    = 12,
  parameter int HALF_NUM = 600
) (
  input  logic [FREQ_W-1:0] code,
  output logic [CNT_W-1:0]  half
);

  localparam int DEPTH = 1 << FREQ_W;

  logic [CNT_W-1:0] romData [DEPTH];

  // Reciprocal table: half-period in clocks for each frequency code.
  // Code 0 is illegal input; it maps to the slowest entry to stay non-zero.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int VAL = (i == 0) ? HALF_NUM : (HALF_NUM / i);
    assign romData[i] = CNT_W'(VAL);
  end

  assign half = romData[code];

endmodule

// File: rtl/tri_fm_carrier_ctrl.sv
module tri_fm_carrier_ctrl
  import tri_fm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] halfCur,
  output logic [CNT_W-1:0] cnt,
  output carrierEvt_t      evt
);

  slope_e phase;

  always_comb begin
    evt.reload = (cnt == '0);
    evt.peak   = (phase == SLOPE_RISE) && (cnt == halfCur) && (cnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= SLOPE_FALL;
    end else if (evt.reload) begin
      // Boundary: the datapath latches the new half-period on this same edge.
      cnt   <= CNT_W'(1);
      phase <= SLOPE_RISE;
    end else if (phase == SLOPE_RISE) begin
      if (cnt >= halfCur) begin
        cnt   <= cnt - CNT_W'(1);
        phase <= SLOPE_FALL;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/tri_fm_profile_dp.sv
module tri_fm_profile_dp
  import tri_fm_pkg::*;
#(
  parameter int FREQ_W   = 6,
  parameter int FUND_W   = 10,
  parameter int CNT_W    = 12,
  parameter int HALF_NUM = 600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FREQ_W-1:0] nomCode,
  input  logic [FREQ_W-1:0] devAmp,
  input  logic [FUND_W-1:0] fundCycles,
  input  carrierEvt_t       evt,
  output logic [CNT_W-1:0]  halfCur
);

  localparam int POS_W  = FREQ_W + 1;
  localparam int CODE_W = FREQ_W + 2;
  localparam int ACC_W  = ((FUND_W > CODE_W) ? FUND_W : CODE_W) + 1;

  logic [POS_W-1:0]  pos;      // profile position, 0 .. 2*devAmp
  slope_e            posDir;
  logic [FUND_W-1:0] acc;      // fractional step accumulator, < fundCycles
  logic [ACC_W-1:0]  accSum;
  logic              stepNow;
  logic [POS_W-1:0]  span;
  logic [POS_W-1:0]  posUp;
  logic [POS_W-1:0]  posDn;
  logic [CODE_W-1:0] codeWide;
  logic [FREQ_W-1:0] codeIdx;
  logic [CNT_W-1:0]  halfNext;

  // Accumulate 4*devAmp per PWM cycle against fundCycles: exactly 4*devAmp
  // profile steps fall into every fundCycles PWM cycles.
  always_comb begin
    accSum   = ACC_W'(acc) + ACC_W'({devAmp, 2'b00});
    stepNow  = accSum >= ACC_W'(fundCycles);
    span     = {devAmp, 1'b0};
    posUp    = pos + POS_W'(1);
    posDn    = pos - POS_W'(1);
    codeWide = CODE_W'(nomCode) - CODE_W'(devAmp) + CODE_W'(pos);
    codeIdx  = codeWide[FREQ_W-1:0];
  end

  tri_fm_recip_rom #(
    .FREQ_W  (FREQ_W),
    .CNT_W   (CNT_W),
    .HALF_NUM(HALF_NUM)
  ) u_rom (
    .code(codeIdx),
    .half(halfNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCur <= '0;
      pos     <= '0;
      posDir  <= SLOPE_RISE;
      acc     <= '0;
    end else if (evt.reload) begin
      halfCur <= halfNext;
      if (stepNow) begin
        acc <= FUND_W'(accSum - ACC_W'(fundCycles));
        if (posDir == SLOPE_RISE) begin
          pos <= posUp;
          if (posUp == span) posDir <= SLOPE_FALL;
        end else begin
          pos <= posDn;
          if (posDn == '0) posDir <= SLOPE_RISE;
        end
      end else begin
        acc <= FUND_W'(accSum);
      end
    end
  end

endmodule

// File: rtl/tri_fm_pwm_timebase.sv
module tri_fm_pwm_timebase
  import tri_fm_pkg::*;
#(
  parameter int FREQ_W   = 6,
  parameter int FUND_W   = 10,
  parameter int CNT_W    = 12,
  parameter int HALF_NUM = 600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FREQ_W-1:0] nomCode,
  input  logic [FREQ_W-1:0] devAmp,
  input  logic [FUND_W-1:0] fundCycles,
  output logic [CNT_W-1:0]  carrierCnt,
  output logic [CNT_W-1:0]  halfPeriod,
  output logic              cycleStart,
  output logic              cycleMid
);

  carrierEvt_t      evt;
  logic [CNT_W-1:0] halfCur;
  logic [CNT_W-1:0] cnt;

  tri_fm_carrier_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .halfCur(halfCur),
    .cnt    (cnt),
    .evt    (evt)
  );

  tri_fm_profile_dp #(
    .FREQ_W  (FREQ_W),
    .FUND_W  (FUND_W),
    .CNT_W   (CNT_W),
    .HALF_NUM(HALF_NUM)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .nomCode   (nomCode),
    .devAmp    (devAmp),
    .fundCycles(fundCycles),
    .evt       (evt),
    .halfCur   (halfCur)
  );

  assign carrierCnt = cnt;
  assign halfPeriod = halfCur;
  assign cycleStart = evt.reload;
  assign cycleMid   = evt.peak;

endmodule

// File: rtl/tri_fm_pwm_timebase_chk.sv
module tri_fm_pwm_timebase_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] carrierCnt,
  input logic [CNT_W-1:0] halfPeriod,
  input logic             cycleStart,
  input logic             cycleMid
);

  // R2: a cycle begins by counting up from zero to one
  a_r2_start_climbs: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> (carrierCnt == CNT_W'(1)));

  // R2: the counter never exceeds the latched half-period
  a_r2_within_half: assert property (@(posedge clk) disable iff (!rstN)
    carrierCnt <= halfPeriod);

  // R3: the two strobes are never high together
  a_r3_strobes_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(cycleStart && cycleMid));

  // R3: the peak strobe marks the top of the triangle
  a_r3_mid_at_half: assert property (@(posedge clk) disable iff (!rstN)
    cycleMid |-> (carrierCnt == halfPeriod));

  // R3: after the peak the counter descends
  a_r3_mid_then_down: assert property (@(posedge clk) disable iff (!rstN)
    cycleMid |=> (carrierCnt == $past(carrierCnt) - CNT_W'(1)));

  // R4: the half-period only moves across a cycle boundary
  a_r4_half_holds: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStart |=> $stable(halfPeriod));

  // R5: a running cycle always has a non-zero half-period
  a_r5_half_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    cycleMid |-> (halfPeriod != '0));

endmodule

bind tri_fm_pwm_timebase tri_fm_pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .carrierCnt(carrierCnt),
  .halfPeriod(halfPeriod),
  .cycleStart(cycleStart),
  .cycleMid  (cycleMid)
);

// File: tb/tb_tri_fm_pwm_timebase.sv
module tb_tri_fm_pwm_timebase;

  localparam int FREQ_W   = 6;
  localparam int FUND_W   = 10;
  localparam int CNT_W    = 12;
  localparam int HALF_NUM = 600;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [FREQ_W-1:0] nomCode = '0;
  logic [FREQ_W-1:0] devAmp = '0;
  logic [FUND_W-1:0] fundCycles = FUND_W'(1);
  logic [CNT_W-1:0]  carrierCnt;
  logic [CNT_W-1:0]  halfPeriod;
  logic              cycleStart;
  logic              cycleMid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  bit modelOn = 0;
  int cfgNom, cfgDev, cfgFund;
  int refT, refH, refK;
  int dutH [256];

  always #5 clk = ~clk;

  tri_fm_pwm_timebase #(
    .FREQ_W(FREQ_W), .FUND_W(FUND_W), .CNT_W(CNT_W), .HALF_NUM(HALF_NUM)
  ) dut (
    .clk(clk), .rstN(rstN), .nomCode(nomCode), .devAmp(devAmp),
    .fundCycles(fundCycles), .carrierCnt(carrierCnt), .halfPeriod(halfPeriod),
    .cycleStart(cycleStart), .cycleMid(cycleMid)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Half-period for PWM cycle k, straight from R5/R6.
  function automatic int refHalf(int k);
    int s, pos;
    pos = 0;
    if (cfgDev != 0) begin
      s = ((4 * cfgDev * k) / cfgFund) % (4 * cfgDev);
      pos = (s <= 2 * cfgDev) ? s : (4 * cfgDev - s);
    end
    return HALF_NUM / (cfgNom - cfgDev + pos);
  endfunction

  task automatic advance();
    if (refT == 0) begin
      refH = refHalf(refK);
      refK++;
      refT = 1;
    end else if (refT == 2 * refH - 1) begin
      refT = 0;
    end else begin
      refT++;
    end
  endtask

  // compared on every clock, between edges
  always @(negedge clk) begin
    if (modelOn) begin
      int expCnt;
      expCnt = (refT <= refH) ? refT : (2 * refH - refT);
      if (refT == 1) dutH[refK-1] = int'(halfPeriod);
      check(int'(carrierCnt) == expCnt, "R2 carrier count", int'(carrierCnt), expCnt);
      check(cycleStart == (refT == 0), "R3 start strobe", int'(cycleStart), int'(refT == 0));
      check(cycleMid == (refT == refH), "R3 mid strobe", int'(cycleMid), int'(refT == refH));
      check(int'(halfPeriod) == refH, "R4 R5 half period", int'(halfPeriod), refH);
      advance();
    end
  end

  task automatic runCfg(int nom, int dev, int fund, int cycles);
    int lo, hi;
    modelOn = 0;
    #1;
    rstN = 1'b0;
    nomCode = FREQ_W'(nom);
    devAmp = FREQ_W'(dev);
    fundCycles = FUND_W'(fund);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(carrierCnt == '0, "R1 reset count", int'(carrierCnt), 0);
    check(halfPeriod == '0, "R1 reset half", int'(halfPeriod), 0);
    check(cycleStart == 1'b1, "R1 reset start", int'(cycleStart), 1);
    check(cycleMid == 1'b0, "R1 reset mid", int'(cycleMid), 0);
    cfgNom = nom; cfgDev = dev; cfgFund = fund;
    refT = 0; refH = 0; refK = 0;
    advance();  // reset-state clock is cycle 0's start clock
    #1;
    rstN = 1'b1;
    modelOn = 1;
    do @(negedge clk); while (refK <= cycles);
    modelOn = 0;
    // R7 periodicity locked to the fundamental
    for (int i = 0; i + fund < cycles; i++)
      check(dutH[i] == dutH[i+fund], "R7 repeat", dutH[i+fund], dutH[i]);
    lo = dutH[0]; hi = dutH[0];
    for (int i = 1; i < fund; i++) begin
      if (dutH[i] < lo) lo = dutH[i];
      if (dutH[i] > hi) hi = dutH[i];
    end
    check(lo == HALF_NUM / (nom + dev), "R7 min half", lo, HALF_NUM / (nom + dev));
    check(hi == HALF_NUM / (nom - dev), "R7 max half", hi, HALF_NUM / (nom - dev));
    // R6 first cycle sits at the bottom of the profile
    check(dutH[0] == HALF_NUM / (nom - dev), "R6 start position", dutH[0], HALF_NUM / (nom - dev));
    if (dev == 0)
      for (int i = 0; i < cycles; i++)
        check(dutH[i] == HALF_NUM / nom, "R8 constant", dutH[i], HALF_NUM / nom);
  endtask

  initial begin
    runCfg(20, 5, 40, 82);   // ordinary sweep
    runCfg(20, 10, 40, 82);  // one step every cycle
    runCfg(30, 0, 16, 34);   // no deviation
    runCfg(50, 3, 25, 52);   // odd fundamental count
    runCfg(5, 4, 17, 36);    // sweep down to code 1
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule